// File: doc/BRIEF.md
# Two-Dimensional Strided Address Generator

The block turns one segment command into a train of row requests for a data mover. A command gives a start address, a row length and a row count (both encoded as count minus one), and a stride. The block then issues one request per row. Each request carries the address where the row begins and the number of bytes in that row. Each row begins one stride after the previous row began, so a gap between rows is expressed by making the stride larger than the row.

When the row-count field is zero the command is a plain linear run: one request of x+1 bytes at the start address, and the stride has no effect. The block accepts a new command only while it is idle. After the request for the last row has been accepted, it raises a one-cycle done pulse. Moving the data and fetching descriptors are handled by other blocks.

Top module: `stride_addr_gen`

## Requirements
- R1: After reset, and before any command, cmd_ready_o is 1 and both req_valid_o and done_o are 0.
- R2: While a command is being worked off, cmd_ready_o is 0, and a command presented during that time leaves the address and byte count of every remaining request unchanged.
- R3: The x field holds the row length minus one. Every request carries req_bytes_o = x+1, so the all-ones x value gives 2^LEN_W bytes.
- R4: The first request carries the start address. Each later request carries the previous request's address plus the stride, wrapping modulo 2^ADDR_W; a stride whose top bit is set therefore steps downward.
- R5: A command with row field y produces exactly y+1 accepted requests and no more.
- R6: When y = 0 the block issues a single request at the start address, and the stride has no effect.
- R7: While req_valid_o is 1 and req_ready_i is 0, req_valid_o, req_addr_o and req_bytes_o hold steady.
- R8: done_o is 1 for exactly the one cycle after the last row's request is accepted, and is 0 at every other time.
- R9: In the cycle where done_o is 1, cmd_ready_o is already 1, so a new command can be accepted back to back.
- R10: The first request of a command is valid in the cycle after the command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Block is idle and takes the command |
| cmd_addr_i | input | ADDR_W | Start address of the first row |
| cmd_xlen_i | input | LEN_W | Bytes per row, minus one |
| cmd_ylen_i | input | ROW_W | Number of rows, minus one |
| cmd_stride_i | input | STRIDE_W | Distance between successive row starts |
| req_valid_o | output | 1 | Row request offered |
| req_ready_i | input | 1 | Consumer takes the row request |
| req_addr_o | output | ADDR_W | Start address of the row |
| req_bytes_o | output | LEN_W+1 | Byte count of the row |
| done_o | output | 1 | One-cycle pulse after the last row is accepted |

## Verification
Two events can fall in the same cycle: the done pulse that closes one command, and the acceptance of the next command. The bench provokes this by presenting each new command in the very cycle where done_o is high. It judges the result by checking that cmd_ready_o is 1 and done_o is 1 together, that done_o has dropped one cycle later, and that the new command's first row appears with the correct address at that point. Commands are also pushed against a busy block while the consumer applies irregular back-pressure, and every row address is compared with a running sum the bench computes itself.

// File: rtl/sag_pkg.sv
package sag_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } sag_state_e;
endpackage

// File: rtl/sag_seq_ctrl.sv
module sag_seq_ctrl
  import sag_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmd_valid_i,
  input  logic req_ready_i,
  input  logic last_row_i,
  output logic cmd_ready_o,
  output logic req_valid_o,
  output logic cmd_fire_o,
  output logic step_o,
  output logic done_o
);
  sag_state_e state_q, state_d;
  logic       done_q;
  logic       req_fire, fin;

  assign cmd_ready_o = (state_q == ST_IDLE);
  assign req_valid_o = (state_q == ST_RUN);
  assign cmd_fire_o  = cmd_valid_i & cmd_ready_o;
  assign req_fire    = req_valid_o & req_ready_i;
  assign step_o      = req_fire & ~last_row_i;
  assign fin         = req_fire & last_row_i;
  assign done_o      = done_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (cmd_fire_o) state_d = ST_RUN;
      ST_RUN:  if (fin)        state_d = ST_IDLE;
      default:                 state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= fin;
    end
  end

  assert_busy_blocks_cmd_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> !cmd_ready_o);
  assert_done_one_cycle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_follows_last_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && req_ready_i && last_row_i |=> done_o && !req_valid_o);
  assert_ready_with_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> cmd_ready_o);
  assert_run_after_accept_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_valid_o) |-> $past(cmd_fire_o));
endmodule

// File: rtl/sag_row_cnt.sv
module sag_row_cnt #(
  parameter int unsigned ROW_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [ROW_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic             last_o
);
  logic [ROW_W-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     left_q <= '0;
    else if (load_i) left_q <= load_val_i;
    else if (dec_i)  left_q <= left_q - ROW_W'(1);
  end

  assign last_o = (left_q == '0);

  assert_no_underflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |-> left_q != '0);
  assert_load_value_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> last_o == ($past(load_val_i) == '0));
endmodule

// File: rtl/sag_addr_acc.sv
module sag_addr_acc #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned STRIDE_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [ADDR_W-1:0]   start_i,
  input  logic                step_i,
  input  logic [STRIDE_W-1:0] stride_i,
  output logic [ADDR_W-1:0]   addr_o
);
  logic [ADDR_W-1:0] stride_ext;
  logic [ADDR_W-1:0] addr_q;

  // stride is fitted to the address width; the sum wraps modulo 2^ADDR_W
  generate
    if (STRIDE_W >= ADDR_W) begin : g_trunc
      assign stride_ext = stride_i[ADDR_W-1:0];
    end else begin : g_zext
      assign stride_ext = {{(ADDR_W-STRIDE_W){1'b0}}, stride_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (load_i) addr_q <= start_i;
    else if (step_i) addr_q <= addr_q + stride_ext;
  end

  assign addr_o = addr_q;

  assert_load_start_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> addr_o == $past(start_i));
  assert_idle_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && !step_i |=> $stable(addr_o));
endmodule

// File: rtl/stride_addr_gen.sv
module stride_addr_gen #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned LEN_W    = 24,
  parameter int unsigned ROW_W    = 32,
  parameter int unsigned STRIDE_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cmd_valid_i,
  output logic                cmd_ready_o,
  input  logic [ADDR_W-1:0]   cmd_addr_i,
  input  logic [LEN_W-1:0]    cmd_xlen_i,
  input  logic [ROW_W-1:0]    cmd_ylen_i,
  input  logic [STRIDE_W-1:0] cmd_stride_i,
  output logic                req_valid_o,
  input  logic                req_ready_i,
  output logic [ADDR_W-1:0]   req_addr_o,
  output logic [LEN_W:0]      req_bytes_o,
  output logic                done_o
);
  localparam int unsigned CNT_W = LEN_W + 1;

  logic                cmd_fire, step, last_row;
  logic [LEN_W-1:0]    xlen_q;
  logic [STRIDE_W-1:0] stride_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xlen_q   <= '0;
      stride_q <= '0;
    end else if (cmd_fire) begin
      xlen_q   <= cmd_xlen_i;
      stride_q <= cmd_stride_i;
    end
  end

  // count-minus-one field widened by one bit so the all-ones value fits
  assign req_bytes_o = CNT_W'(xlen_q) + CNT_W'(1);

  sag_seq_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .req_ready_i (req_ready_i),
    .last_row_i  (last_row),
    .cmd_ready_o (cmd_ready_o),
    .req_valid_o (req_valid_o),
    .cmd_fire_o  (cmd_fire),
    .step_o      (step),
    .done_o      (done_o)
  );

  sag_row_cnt #(.ROW_W(ROW_W)) u_rows (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (cmd_fire),
    .load_val_i (cmd_ylen_i),
    .dec_i      (step),
    .last_o     (last_row)
  );

  sag_addr_acc #(.ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W)) u_addr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (cmd_fire),
    .start_i  (cmd_addr_i),
    .step_i   (step),
    .stride_i (stride_q),
    .addr_o   (req_addr_o)
  );

  assert_req_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_addr_o) && $stable(req_bytes_o));
  assert_first_row_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd_ready_o |=> req_valid_o && req_addr_o == $past(cmd_addr_i)
      && req_bytes_o == CNT_W'($past(cmd_xlen_i)) + CNT_W'(1));
  assert_row_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && req_ready_i && !done_o |=> !req_valid_o || done_o
      || req_addr_o == $past(req_addr_o) + ADDR_W'($past(stride_q)));
  assert_single_row_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd_ready_o && cmd_ylen_i == '0 |=> req_valid_o && last_row);
  assert_bytes_stable_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && $past(req_valid_o) |-> $stable(req_bytes_o));
endmodule

// File: tb/stride_addr_gen_bench.sv
module stride_addr_gen_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_valid_i = 1'b0;
  logic        cmd_ready_o;
  logic [31:0] cmd_addr_i = '0;
  logic [23:0] cmd_xlen_i = '0;
  logic [31:0] cmd_ylen_i = '0;
  logic [31:0] cmd_stride_i = '0;
  logic        req_valid_o;
  logic        req_ready_i = 1'b0;
  logic [31:0] req_addr_o;
  logic [24:0] req_bytes_o;
  logic        done_o;

  int n_total = 0;
  int n_fail  = 0;
  int cyc     = 0;

  always #2ns clk_i = ~clk_i;

  stride_addr_gen u_stride_addr_gen (
    .clk_i, .rst_ni, .cmd_valid_i, .cmd_ready_o, .cmd_addr_i, .cmd_xlen_i,
    .cmd_ylen_i, .cmd_stride_i, .req_valid_o, .req_ready_i, .req_addr_o,
    .req_bytes_o, .done_o
  );

  typedef struct packed {
    logic [31:0] a;
    logic [23:0] x;
    logic [31:0] y;
    logic [31:0] s;
    logic [7:0]  m;   // stall mask, bit set = consumer not ready
  } vec_t;

  localparam int NV = 6;
  localparam vec_t TBL [NV] = '{
    '{32'h0000_1000, 24'd3,    32'd3, 32'h0000_0040, 8'h00},  // plain 2D
    '{32'h2000_0010, 24'hFF,   32'd0, 32'h0000_0123, 8'hA5},  // 1D, stride unused
    '{32'hFFFF_FF00, 24'h0F,   32'd4, 32'h0000_0080, 8'h63},  // address wrap
    '{32'h0000_0000, 24'd0,    32'd5, 32'h0000_0001, 8'h00},  // one-byte rows
    '{32'h0000_8000, 24'h3F,   32'd2, 32'h0000_0040, 8'hFE},  // contiguous, heavy stall
    '{32'h1234_5678, 24'd7,    32'd1, 32'hFFFF_FFF0, 8'h0C}   // downward stride
  };

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // called at a negedge with the block idle; returns at the negedge where done_o is high
  task automatic run_cmd(input logic [31:0] a, input logic [23:0] x, input logic [31:0] y,
                         input logic [31:0] s, input logic [7:0] m, input bit poke);
    logic [31:0] ea;
    int rows;
    int k;
    bit stalled;
    chk(cmd_ready_o === 1'b1, "R9 cmd_ready when idle", 64'(cmd_ready_o), 64'd1);
    cmd_valid_i = 1'b1; cmd_addr_i = a; cmd_xlen_i = x; cmd_ylen_i = y; cmd_stride_i = s;
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
    chk(done_o === 1'b0, "R8 done low while busy", 64'(done_o), 64'd0);
    ea = a; rows = 0; k = 0; stalled = 1'b0;
    while (rows <= int'(y)) begin
      chk(req_valid_o === 1'b1, stalled ? "R7 valid held" : "R10 row valid", 64'(req_valid_o), 64'd1);
      chk(req_addr_o === ea, stalled ? "R7 addr held" : "R4 row addr", 64'(req_addr_o), 64'(ea));
      chk(req_bytes_o === 25'(x) + 25'd1, "R3 row bytes", 64'(req_bytes_o), 64'(25'(x) + 25'd1));
      chk(cmd_ready_o === 1'b0, "R2 not ready while busy", 64'(cmd_ready_o), 64'd0);
      if (poke) begin
        cmd_valid_i = 1'b1; cmd_addr_i = 32'hDEAD_0000 + 32'(k);
        cmd_xlen_i = 24'h5; cmd_ylen_i = 32'd9; cmd_stride_i = 32'h77;
      end
      req_ready_i = ~m[k % 8];
      k++;
      @(negedge clk_i);
      stalled = ~req_ready_i;
      if (req_ready_i) begin
        rows++;
        ea = ea + s;
      end
    end
    req_ready_i = 1'b0;
    cmd_valid_i = 1'b0;
    chk(done_o === 1'b1, "R8 done after last row", 64'(done_o), 64'd1);
    chk(req_valid_o === 1'b0, "R5 no extra request", 64'(req_valid_o), 64'd0);
    chk(cmd_ready_o === 1'b1, "R9 ready in done cycle", 64'(cmd_ready_o), 64'd1);
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 50000) begin
      n_total++; n_fail++;
      $display("FAIL watchdog R8 actual=%0d expected=done", cyc);
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: reset state while reset held and after release
    chk(cmd_ready_o === 1'b1 && req_valid_o === 1'b0 && done_o === 1'b0, "R1 state in reset",
        {61'd0, cmd_ready_o, req_valid_o, done_o}, 64'b100);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(cmd_ready_o === 1'b1 && req_valid_o === 1'b0 && done_o === 1'b0, "R1 state after reset",
        {61'd0, cmd_ready_o, req_valid_o, done_o}, 64'b100);

    // table walk; each command starts in the previous done cycle (R9 back to back)
    for (int i = 0; i < NV; i++) begin
      run_cmd(TBL[i].a, TBL[i].x, TBL[i].y, TBL[i].s, TBL[i].m, 1'b0);
    end
    @(negedge clk_i);
    chk(done_o === 1'b0, "R8 done falls after one cycle", 64'(done_o), 64'd0);
    chk(req_valid_o === 1'b0, "R5 idle after table", 64'(req_valid_o), 64'd0);

    // R2: commands pushed while busy must not disturb rows
    run_cmd(32'h0004_0000, 24'd15, 32'd3, 32'h100, 8'h24, 1'b1);
    @(negedge clk_i);
    chk(req_valid_o === 1'b0, "R2 busy command not taken", 64'(req_valid_o), 64'd0);

    // R3: largest row length
    run_cmd(32'h0010_0000, 24'hFF_FFFF, 32'd1, 32'h0100_0000, 8'h00, 1'b0);
    @(negedge clk_i);

    // R6: 1D with large stride, only one request, then idle
    run_cmd(32'hABCD_0000, 24'd31, 32'd0, 32'hFFFF_FFFF, 8'h01, 1'b0);
    @(negedge clk_i);
    chk(done_o === 1'b0 && req_valid_o === 1'b0, "R6 single row only",
        {62'd0, done_o, req_valid_o}, 64'd0);
    repeat (4) @(negedge clk_i);
    chk(req_valid_o === 1'b0 && cmd_ready_o === 1'b1, "R6 stays idle",
        {62'd0, req_valid_o, cmd_ready_o}, 64'b01);

    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule